// File: doc/BRIEF.md
# I2C Controller Byte Queues and Interrupt Status

This block sits between a processor register port and an I2C bus engine. It owns two byte queues, one per direction. Software writes outgoing bytes into the transmit queue, and the engine pops them. The engine pushes received bytes into the receive queue, and software reads them out. Each queue has a programmable 4-bit threshold. Each queue also has a flush control bit. Writing that bit empties the queue over several clock cycles. The bit reads back as one until the flush has finished, and the queue ignores all traffic in the meantime.

The block also gathers interrupt status. Fill conditions of the two queues appear as level bits that follow the queue contents. A transmit overrun, and the done, done-without-stop, arbitration-lost and bus-error pulses from the engine, appear as sticky event bits. A mask register selects which bits raise the single interrupt line. A write-one-to-clear register drops sticky events. The bit positions are fixed so that existing software decoding stays valid.

Top module: `i2c_fifo_irq_hub`

## Requirements
- R1: After reset both queues are empty, the mask reads 0, the interrupt output is low, the transmit threshold is 0, the receive threshold is 1, and the raw status reads 0x00000013.
- R2: Bytes written to the transmit data register (word 1) reach the engine in write order. The engine sees a byte available only while the queue is non-empty and not flushing.
- R3: Bytes pushed by the engine are returned in push order by reads of the receive data register (word 2). Each read removes one byte. A read of an empty queue returns 0.
- R4: Raw bit 1 is set while the transmit fill level is less than or equal to the transmit threshold (word 3). Raw bit 0 is set while the transmit queue is empty, and raw bit 2 while it holds DEPTH bytes.
- R5: Raw bit 5 is set while the receive fill level is greater than or equal to the receive threshold (word 4). Raw bit 4 is set while the receive queue is empty, and raw bit 6 while it is full.
- R6: A transmit data write while the transmit queue is full is dropped and sets sticky raw bit 3.
- R7: Writing 1 to control bit 0 (transmit) or control bit 1 (receive) of word 0 starts a flush. The bit reads 1 for FLUSH_CYCLES cycles, and the queue is then empty. Pushes and pops issued during the flush are ignored.
- R8: The mask (word 5) stores written bits except bits 31..29, which read 0. The masked status (word 7) equals raw status AND mask.
- R9: Writing ones to word 8 clears the sticky event bits at those positions. Only positions within 0x131F007F are affected. Level bits keep following the queues.
- R10: Engine pulses set sticky raw bits 19 (done), 28 (done without stop), 24 (arbitration lost) and 25 (bus error). A bit stays set until it is cleared through word 8.
- R11: The interrupt output is high exactly when raw status AND mask is non-zero.
- R12: An engine push into a full receive queue is dropped, and the room indication to the engine is low while the queue is full or flushing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rack is high |
| reg_rack | output | 1 | High one cycle after a read access |
| eng_tx_pop | input | 1 | Engine takes the head transmit byte |
| eng_tx_data | output | 8 | Head transmit byte |
| eng_tx_avail | output | 1 | Transmit byte available |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_room | output | 1 | Receive queue can accept a byte |
| eng_evt_done | input | 1 | Transfer done pulse |
| eng_evt_nostop | input | 1 | Transfer done without stop pulse |
| eng_evt_arb | input | 1 | Arbitration lost pulse |
| eng_evt_berr | input | 1 | Bus error pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: 16-entry queues (AW of 4) and a 4-cycle flush. With these values the largest threshold of 15 still sits below the full level, so both full flags, the dropped transmit overrun write and the dropped receive push at the full level can be reached with short bursts. The short flush lets the bench issue a control readback and a data write that must be ignored while the flush is still running.

// File: rtl/i2cfq_pkg.sv
// Shared constants for the I2C byte queue and interrupt block.
// Assumes a 32-bit register word and a 4-bit register word index.
package i2cfq_pkg;
    // Interrupt bit positions; software decodes these, so they are fixed.
    localparam int BIT_TX_EMPTY  = 0;
    localparam int BIT_TX_NEMPTY = 1;
    localparam int BIT_TX_FULL   = 2;
    localparam int BIT_TX_OVR    = 3;
    localparam int BIT_RX_EMPTY  = 4;
    localparam int BIT_RX_NFULL  = 5;
    localparam int BIT_RX_FULL   = 6;
    localparam int BIT_DONE      = 19;
    localparam int BIT_ARB       = 24;
    localparam int BIT_BERR      = 25;
    localparam int BIT_NOSTOP    = 28;

    localparam logic [31:0] CLEARABLE = 32'h131F_007F;
    localparam logic [31:0] MASK_KEEP = 32'h1FFF_FFFF;

    // Register word indices.
    localparam logic [3:0] RG_CTRL  = 4'd0;
    localparam logic [3:0] RG_TXD   = 4'd1;
    localparam logic [3:0] RG_RXD   = 4'd2;
    localparam logic [3:0] RG_TXTHR = 4'd3;
    localparam logic [3:0] RG_RXTHR = 4'd4;
    localparam logic [3:0] RG_MASK  = 4'd5;
    localparam logic [3:0] RG_RAW   = 4'd6;
    localparam logic [3:0] RG_MSKD  = 4'd7;
    localparam logic [3:0] RG_CLR   = 4'd8;
    localparam logic [3:0] RG_LVL   = 4'd9;
endpackage

// File: rtl/i2cfq_byte_queue.sv
// Byte queue with show-ahead head output and a multi-cycle flush.
// Assumes: push/pop are ignored when illegal (full/empty) or while a
// flush runs; flush_req is ignored while a flush is already running.
// FLUSH_CYCLES must be at least 1.
module i2cfq_byte_queue #(
    parameter int AW           = 4,
    parameter int FLUSH_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_req,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [AW:0]   count,
    output logic          flushing,
    output logic          full,
    output logic          empty
);
    localparam int DEPTH = 1 << AW;
    localparam int TW    = (FLUSH_CYCLES > 2) ? $clog2(FLUSH_CYCLES) : 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [TW-1:0] ftmr;
    logic          do_push;
    logic          do_pop;
    logic          flush_end;

    assign full      = (count == (AW+1)'(DEPTH));
    assign empty     = (count == '0);
    assign do_push   = push && !full && !flushing;
    assign do_pop    = pop && !empty && !flushing;
    assign flush_end = flushing && (ftmr == '0);
    assign head      = mem[rd_ptr];

    // Flush timer: holds flushing high for FLUSH_CYCLES cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flushing <= 1'b0;
            ftmr     <= '0;
        end else if (flushing) begin
            if (ftmr == '0) flushing <= 1'b0;
            else            ftmr     <= ftmr - 1'b1;
        end else if (flush_req) begin
            flushing <= 1'b1;
            ftmr     <= TW'(FLUSH_CYCLES - 1);
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and fill level bookkeeping, emptied at flush end.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_end) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/i2cfq_irq_status.sv
// Interrupt status: level bits from queue fill state, sticky event bits,
// mask with reserved top bits, masked view and a single request line.
// Assumes set and clear of the same event in one cycle leaves it set.
module i2cfq_irq_status
    import i2cfq_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW:0]   tx_count,
    input  logic [AW:0]   rx_count,
    input  logic [AW-1:0] tx_thr,
    input  logic [AW-1:0] rx_thr,
    input  logic          tx_full,
    input  logic          tx_empty,
    input  logic          rx_full,
    input  logic          rx_empty,
    input  logic [31:0]   evt_set,
    input  logic          clr_we,
    input  logic          mask_we,
    input  logic [31:0]   wdata,
    output logic [31:0]   raw,
    output logic [31:0]   mask,
    output logic [31:0]   masked,
    output logic          irq
);
    localparam logic [31:0] EVT_BITS = (32'd1 << BIT_TX_OVR) | (32'd1 << BIT_DONE) |
                                       (32'd1 << BIT_ARB) | (32'd1 << BIT_BERR) |
                                       (32'd1 << BIT_NOSTOP);

    logic [31:0] evt_q;
    logic [31:0] lvl;

    // Level conditions derived from the queue state.
    always_comb begin
        lvl = '0;
        lvl[BIT_TX_EMPTY]  = tx_empty;
        lvl[BIT_TX_NEMPTY] = (tx_count <= {1'b0, tx_thr});
        lvl[BIT_TX_FULL]   = tx_full;
        lvl[BIT_RX_EMPTY]  = rx_empty;
        lvl[BIT_RX_NFULL]  = (rx_count >= {1'b0, rx_thr});
        lvl[BIT_RX_FULL]   = rx_full;
    end

    // Sticky events: set by pulses, cleared by write-one within CLEARABLE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= ((evt_q & ~(clr_we ? (wdata & CLEARABLE) : 32'd0)) | evt_set) & EVT_BITS;
        end
    end

    // Mask register with reserved top bits held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= wdata & MASK_KEEP;
    end

    assign raw    = lvl | evt_q;
    assign masked = raw & mask;
    assign irq    = |masked;
endmodule

// File: rtl/i2c_fifo_irq_hub.sv
// Top: register decode, thresholds, flush control, the two byte queues
// and the interrupt status block.
// Assumes one register access per cycle; read data is registered and
// qualified by reg_rack one cycle after the access. AW must be at most 7.
module i2c_fifo_irq_hub
    import i2cfq_pkg::*;
#(
    parameter int AW           = 4,
    parameter int FLUSH_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_valid,
    input  logic        reg_write,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_rack,
    input  logic        eng_tx_pop,
    output logic [7:0]  eng_tx_data,
    output logic        eng_tx_avail,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_data,
    output logic        eng_rx_room,
    input  logic        eng_evt_done,
    input  logic        eng_evt_nostop,
    input  logic        eng_evt_arb,
    input  logic        eng_evt_berr,
    output logic        irq_o
);
    localparam int CW = AW + 1;

    logic          wr_en;
    logic          rd_en;
    logic [AW-1:0] tx_thr;
    logic [AW-1:0] rx_thr;
    logic [CW-1:0] tx_count;
    logic [CW-1:0] rx_count;
    logic          tx_flushing;
    logic          rx_flushing;
    logic          tx_full;
    logic          tx_empty;
    logic          rx_full;
    logic          rx_empty;
    logic [7:0]    rx_head;
    logic          tx_push;
    logic          rx_pop;
    logic          tx_flush_req;
    logic          rx_flush_req;
    logic [31:0]   evt_set;
    logic [31:0]   raw;
    logic [31:0]   mask;
    logic [31:0]   masked;

    assign wr_en        = reg_valid && reg_write;
    assign rd_en        = reg_valid && !reg_write;
    assign tx_push      = wr_en && (reg_addr == RG_TXD);
    assign rx_pop       = rd_en && (reg_addr == RG_RXD);
    assign tx_flush_req = wr_en && (reg_addr == RG_CTRL) && reg_wdata[0];
    assign rx_flush_req = wr_en && (reg_addr == RG_CTRL) && reg_wdata[1];

    assign eng_tx_avail = !tx_empty && !tx_flushing;
    assign eng_rx_room  = !rx_full && !rx_flushing;

    // Threshold registers; the receive side starts at 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr <= '0;
            rx_thr <= AW'(1);
        end else if (wr_en) begin
            if (reg_addr == RG_TXTHR) tx_thr <= reg_wdata[AW-1:0];
            if (reg_addr == RG_RXTHR) rx_thr <= reg_wdata[AW-1:0];
        end
    end

    // Event pulses gathered into their status positions.
    always_comb begin
        evt_set = '0;
        evt_set[BIT_TX_OVR] = tx_push && tx_full && !tx_flushing;
        evt_set[BIT_DONE]   = eng_evt_done;
        evt_set[BIT_ARB]    = eng_evt_arb;
        evt_set[BIT_BERR]   = eng_evt_berr;
        evt_set[BIT_NOSTOP] = eng_evt_nostop;
    end

    i2cfq_byte_queue #(.AW(AW), .FLUSH_CYCLES(FLUSH_CYCLES)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_req (tx_flush_req),
        .push      (tx_push),
        .push_data (reg_wdata[7:0]),
        .pop       (eng_tx_pop),
        .head      (eng_tx_data),
        .count     (tx_count),
        .flushing  (tx_flushing),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    i2cfq_byte_queue #(.AW(AW), .FLUSH_CYCLES(FLUSH_CYCLES)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_req (rx_flush_req),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_count),
        .flushing  (rx_flushing),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    i2cfq_irq_status #(.AW(AW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_count (tx_count),
        .rx_count (rx_count),
        .tx_thr   (tx_thr),
        .rx_thr   (rx_thr),
        .tx_full  (tx_full),
        .tx_empty (tx_empty),
        .rx_full  (rx_full),
        .rx_empty (rx_empty),
        .evt_set  (evt_set),
        .clr_we   (wr_en && (reg_addr == RG_CLR)),
        .mask_we  (wr_en && (reg_addr == RG_MASK)),
        .wdata    (reg_wdata),
        .raw      (raw),
        .mask     (mask),
        .masked   (masked),
        .irq      (irq_o)
    );

    // Registered read path with one-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
            reg_rack  <= 1'b0;
        end else begin
            reg_rack <= rd_en;
            if (rd_en) begin
                unique case (reg_addr)
                    RG_CTRL:  reg_rdata <= {30'd0, rx_flushing, tx_flushing};
                    RG_RXD:   reg_rdata <= (!rx_empty && !rx_flushing) ? {24'd0, rx_head} : 32'd0;
                    RG_TXTHR: reg_rdata <= 32'(tx_thr);
                    RG_RXTHR: reg_rdata <= 32'(rx_thr);
                    RG_MASK:  reg_rdata <= mask;
                    RG_RAW:   reg_rdata <= raw;
                    RG_MSKD:  reg_rdata <= masked;
                    RG_LVL:   reg_rdata <= {16'd0, 8'(rx_count), 8'(tx_count)};
                    default:  reg_rdata <= 32'd0;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cfq_checker.sv
// Property checker for i2c_fifo_irq_hub, attached by bind below.
// Assumes it sees the top's internal queue and status signals by name.
module i2cfq_checker #(
    parameter int AW = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_valid,
    input logic        reg_write,
    input logic [3:0]  reg_addr,
    input logic        tx_full,
    input logic        tx_flushing,
    input logic        rx_full,
    input logic        rx_flushing,
    input logic [AW:0] tx_count,
    input logic [AW:0] rx_count,
    input logic [31:0] raw,
    input logic [31:0] mask,
    input logic        irq_o,
    input logic        eng_evt_arb
);
    localparam int DEPTH = 1 << AW;

    // R2: transmit fill level never exceeds the depth.
    assert_tx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= (AW+1)'(DEPTH));

    // R6: write into a full transmit queue raises the overrun bit.
    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_addr == 4'd1 && tx_full && !tx_flushing) |=> raw[3]);

    // R7: the queue is empty as soon as a flush finishes.
    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_flushing) |-> (tx_count == '0));

    // R8: reserved mask bits are never set.
    always_comb begin
        if (rst_n) assert_mask_reserved_R8: assert (mask[31:29] == 3'b000);
    end

    // R10: an arbitration-lost pulse leaves its sticky bit set.
    assert_arb_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_evt_arb |=> raw[24]);

    // R11: request line matches the masked status.
    assert_irq_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(raw & mask));

    // R12: a full receive queue without a read keeps its level.
    assert_rx_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_flushing && !(reg_valid && !reg_write && reg_addr == 4'd2))
        |=> (rx_count == $past(rx_count)));
endmodule

bind i2c_fifo_irq_hub i2cfq_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_valid   (reg_valid),
    .reg_write   (reg_write),
    .reg_addr    (reg_addr),
    .tx_full     (tx_full),
    .tx_flushing (tx_flushing),
    .rx_full     (rx_full),
    .rx_flushing (rx_flushing),
    .tx_count    (tx_count),
    .rx_count    (rx_count),
    .raw         (raw),
    .mask        (mask),
    .irq_o       (irq_o),
    .eng_evt_arb (eng_evt_arb)
);

// File: tb/i2c_fifo_irq_hub_tb_top.sv
`timescale 1ns/1ps
module i2c_fifo_irq_hub_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rack;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_tx_data;
    logic        eng_tx_avail;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        eng_rx_room;
    logic        eng_evt_done = 1'b0;
    logic        eng_evt_nostop = 1'b0;
    logic        eng_evt_arb = 1'b0;
    logic        eng_evt_berr = 1'b0;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    i2c_fifo_irq_hub dut_i (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rdreg(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        d = reg_rdata;
    endtask

    // Driver: software-side transmit write, expected byte queued.
    task automatic tx_send(logic [7:0] b);
        tx_q.push_back(b);
        wr(4'd1, {24'd0, b});
    endtask

    // Monitor-side compare for the engine pop (R2).
    task automatic tx_take();
        logic [7:0] e;
        @(negedge clk);
        e = tx_q.pop_front();
        check("R2 avail", {31'd0, eng_tx_avail}, 32'd1);
        check("R2 order", {24'd0, eng_tx_data}, {24'd0, e});
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic rx_put(logic [7:0] b, bit expect_kept);
        @(negedge clk);
        if (expect_kept) rx_q.push_back(b);
        eng_rx_push = 1'b1; eng_rx_data = b;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic rx_get();
        logic [31:0] d;
        logic [7:0] e;
        rdreg(4'd2, d);
        e = rx_q.pop_front();
        check("R3 order", d, {24'd0, e});
    endtask

    task automatic pulse(int which);
        @(negedge clk);
        case (which)
            0: eng_evt_done = 1'b1;
            1: eng_evt_nostop = 1'b1;
            2: eng_evt_arb = 1'b1;
            default: eng_evt_berr = 1'b1;
        endcase
        @(negedge clk);
        eng_evt_done = 0; eng_evt_nostop = 0; eng_evt_arb = 0; eng_evt_berr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rdreg(4'd6, rd); check("R1 raw", rd, 32'h13);
        rdreg(4'd5, rd); check("R1 mask", rd, 32'h0);
        rdreg(4'd9, rd); check("R1 levels", rd, 32'h0);
        rdreg(4'd4, rd); check("R1 rx thr", rd, 32'h1);
        check("R1 irq", {31'd0, irq_o}, 32'd0);
        rdreg(4'd2, rd); check("R3 empty read", rd, 32'h0);

        // R2/R4 transmit order and nearly-empty threshold
        wr(4'd3, 32'd3);
        wr(4'd4, 32'd4);
        for (int i = 0; i < 5; i++) tx_send(8'hA0 + 8'(i));
        rdreg(4'd6, rd); check("R4 nearly empty off at 5>3", {31'd0, rd[1]}, 32'd0);
        tx_take(); tx_take();
        rdreg(4'd6, rd); check("R4 nearly empty on at 3<=3", {31'd0, rd[1]}, 32'd1);
        tx_take(); tx_send(8'h5C); tx_take(); tx_take(); tx_take();
        check("R2 avail low when empty", {31'd0, eng_tx_avail}, 32'd0);

        // R3/R5 receive order and nearly-full threshold
        for (int i = 0; i < 3; i++) rx_put(8'h30 + 8'(i), 1);
        rdreg(4'd6, rd); check("R5 nearly full off at 3<4", {31'd0, rd[5]}, 32'd0);
        rx_put(8'h33, 1);
        rdreg(4'd6, rd); check("R5 nearly full on at 4", rd & 32'h70, 32'h20);
        for (int i = 0; i < 4; i++) rx_get();

        // R4/R6 full and overrun
        for (int i = 0; i < 16; i++) tx_send(8'(i * 7));
        rdreg(4'd6, rd); check("R4 tx full", rd & 32'hF, 32'h4);
        wr(4'd1, 32'hEE);
        rdreg(4'd6, rd); check("R6 overrun set", rd & 32'hF, 32'hC);
        rdreg(4'd9, rd); check("R6 level kept", rd & 32'hFF, 32'd16);
        wr(4'd8, 32'hFFFF_FFFF);
        rdreg(4'd6, rd); check("R9 overrun cleared, full kept", rd & 32'hF, 32'h4);
        tx_take(); tx_take();

        // R7 transmit flush
        wr(4'd0, 32'h1);
        rdreg(4'd0, rd); check("R7 flush bit busy", rd, 32'h1);
        wr(4'd1, 32'h99);
        repeat (6) @(negedge clk);
        rdreg(4'd0, rd); check("R7 flush bit cleared", rd, 32'h0);
        rdreg(4'd9, rd); check("R7 tx empty after flush", rd & 32'hFF, 32'h0);
        check("R7 no avail after flush", {31'd0, eng_tx_avail}, 32'd0);
        tx_q.delete();
        tx_send(8'h42); tx_take();

        // R12/R5 receive full, drop, flush
        for (int i = 0; i < 16; i++) rx_put(8'(i), 1);
        check("R12 no room when full", {31'd0, eng_rx_room}, 32'd0);
        rx_put(8'hFF, 0);
        rdreg(4'd9, rd); check("R12 push dropped", rd & 32'hFF00, 32'h1000);
        rdreg(4'd6, rd); check("R5 rx full", {31'd0, rd[6]}, 32'd1);
        rx_get(); rx_get();
        wr(4'd0, 32'h2);
        rdreg(4'd0, rd); check("R7 rx flush busy", rd, 32'h2);
        repeat (6) @(negedge clk);
        rdreg(4'd9, rd); check("R7 rx empty after flush", rd, 32'h0);
        rx_q.delete();

        // R8/R10/R11 events, mask, clear
        pulse(2);
        rdreg(4'd6, rd); check("R10 arb sticky", {31'd0, rd[24]}, 32'd1);
        check("R11 irq low with zero mask", {31'd0, irq_o}, 32'd0);
        wr(4'd5, 32'hFFFF_FFFF);
        rdreg(4'd5, rd); check("R8 mask reserved", rd, 32'h1FFF_FFFF);
        rdreg(4'd7, rd); check("R8 masked view", rd, 32'h0100_0013);
        check("R11 irq high", {31'd0, irq_o}, 32'd1);
        wr(4'd5, 32'h1000_0000 | 32'h0200_0000 | 32'h0008_0000 | 32'h0100_0000);
        wr(4'd8, 32'h0100_0000);
        @(negedge clk);
        check("R9 arb cleared, irq low", {31'd0, irq_o}, 32'd0);
        pulse(0); pulse(1); pulse(3);
        rdreg(4'd6, rd); check("R10 done/nostop/berr", rd & 32'h1308_0000, 32'h1208_0000);
        check("R11 irq from events", {31'd0, irq_o}, 32'd1);
        wr(4'd8, 32'h1208_0000);
        rdreg(4'd6, rd); check("R9 events cleared", rd, 32'h13);
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (200000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule